// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block drives the control strobes of a NAND flash bus: chip enable, write enable, read enable, and the command and address latch enables. It also drives the output data bus and its output enable. A host issues byte cycles through a valid/acknowledge request port. Each request is a command byte, an address byte, a data write or a data read. The block runs the matching pin sequence, returns read data, and pulses an acknowledge when the cycle is over. Every interval is counted in host clocks and comes from its own field of one packed timing word. A count value of N gives a phase of N+1 clocks, so a zero field still gives a one-clock phase.

The timing word and two small mode registers sit behind a key lock. A write to any of them takes effect only if the configuration write just before it put the key value into the lock register. The unlock is spent by that single write. A write request can ask the block to wait for the device after the byte, for example after a program or read-start command. In that case the block waits a programmed delay and then holds until the ready/busy pin reports ready. Two status outputs report device readiness and controller idleness.

Top module: `nand_strobe_gen`

## Requirements
- R1: During and straight after reset: ce_n, we_n and re_n are high, dq_oe is low, req_ack is low, stat_ctrl_rdy is high, stat_nand_rdy is low, both interface bits are low, CE runs in normal mode and the lock is closed.
- R2: In a non-read request (req_kind 0 = command, 1 = address, 2 = data write), we_n is low for wr_low+1 clocks, where wr_low is timing bits 3:0. It is then high for wr_high+1 clocks, where wr_high is bits 7:4. The data bus carries req_wdata with dq_oe high from the setup phase to the end of the high phase. cle is high in that span for a command only, and ale is high in that span for an address only.
- R3: In a read request (req_kind 3), re_n is low for rd_low+1 clocks (bits 11:8) and then high for rd_high+1 clocks (bits 15:12). A turnaround of turn+1 clocks follows (bits 18:16). dq_oe stays low, and rsp_rdata holds the value of nand_dq_i seen in the last low clock.
- R4: In normal CE mode, ce_n goes low ce_setup+1 clocks (bits 25:24) before the first strobe-low clock. It stays low through the strobe, and it is high whenever the block is idle.
- R5: req_ack is a single-clock pulse. It comes in the clock after the last timed phase, so a request takes the sum of its phase lengths plus one clock.
- R6: If req_busy is set on a non-read request, then after the high phase the block waits busy_dly+1 clocks (bits 23:19). It then waits until the registered ready/busy pin is high. No acknowledge is given while the pin is low.
- R7: A configuration write with cfg_sel 1 (timing), 2 (interface) or 3 (CE mode) takes effect only if the configuration write just before it put 0x0000A25E into cfg_sel 0. Any write with cfg_sel 1, 2 or 3 closes the lock again. Writing any other value to cfg_sel 0 also closes it.
- R8: Interface register bit 2 drives iface_large_blk and bit 1 drives iface_addr4.
- R9: CE mode register bit 0 set gives normal CE. When it is clear, ce_n is held low at all times, including idle.
- R10: stat_nand_rdy is nand_rb_n delayed by one clock. stat_ctrl_rdy is high only while no request is in progress.
- R11: we_n and re_n are never low in the same clock, and ce_n is low whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 lock, 1 timing, 2 interface, 3 CE mode |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request pending; held until req_ack |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_busy | input | 1 | Wait for device ready after this non-read byte |
| req_wdata | input | 8 | Byte to drive for non-read requests |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| stat_nand_rdy | output | 1 | Registered ready/busy pin |
| stat_ctrl_rdy | output | 1 | Controller idle |
| iface_large_blk | output | 1 | Large-page device selected |
| iface_addr4 | output | 1 | Four-byte addressing selected |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Output data bus |
| nand_dq_oe | output | 1 | Output data bus enable |
| nand_dq_i | input | 8 | Input data bus |
| nand_rb_n | input | 1 | Ready/busy pin, high when ready |

## Verification
The bench runs all-zero and all-ones timing words, which expose an off-by-one in the count+1 rule. With such a fault every phase comes out one clock short or long, or a zero field collapses a phase to nothing. It also mixes random timing words with random request kinds, so each field is checked in its own bit position. A swapped field shows up as a wrong strobe width or a wrong total cycle count.

The lock is probed three ways: a write with no key, a second write after one unlocked write, and a wrong key. A design that left the lock open would take the new timing and stretch the measured strobe. The busy path holds the ready/busy pin low for a long time. This catches a design that acknowledges before the device is ready or never wakes on its release. The forced-CE mode catches a chip enable that lifts between cycles.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

    // Request kinds seen on req_kind
    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READ  = 2'd3
    } xfer_kind_e;

    // Configuration register select
    typedef enum logic [1:0] {
        SEL_LOCK   = 2'd0,
        SEL_TIMING = 2'd1,
        SEL_IFACE  = 2'd2,
        SEL_CEMODE = 2'd3
    } cfg_sel_e;

    // Packed timing word; member order fixes the bit positions (LSB last)
    typedef struct packed {
        logic [1:0] ce_setup;   // 25:24
        logic [4:0] busy_dly;   // 23:19
        logic [2:0] turn;       // 18:16
        logic [3:0] rd_high;    // 15:12
        logic [3:0] rd_low;     // 11:8
        logic [3:0] wr_high;    // 7:4
        logic [3:0] wr_low;     // 3:0
    } timing_t;

    localparam int unsigned TIM_W = $bits(timing_t);
    localparam int unsigned CNT_W = 5;   // wide enough for the widest field

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TURN,
        ST_BUSY_DLY,
        ST_BUSY_WAIT,
        ST_DONE
    } phase_e;

endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
    import nand_strobe_pkg::*;
#(
    parameter int unsigned CFG_W        = 32,
    parameter logic [31:0] UNLOCK_KEY   = 32'h0000_A25E,
    parameter logic [31:0] RESET_TIMING = 32'h03FF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output timing_t          timing_o,
    output logic             large_blk_o,
    output logic             addr4_o,
    output logic             ce_normal_o
);

    typedef struct packed {
        logic    unlocked;
        timing_t timing;
        logic    large_blk;
        logic    addr4;
        logic    ce_normal;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            if (cfg_sel == SEL_LOCK) begin
                cfg_d.unlocked = (cfg_wdata == CFG_W'(UNLOCK_KEY));
            end else begin
                if (cfg_q.unlocked) begin
                    unique case (cfg_sel)
                        SEL_TIMING: cfg_d.timing = timing_t'(cfg_wdata[TIM_W-1:0]);
                        SEL_IFACE: begin
                            cfg_d.large_blk = cfg_wdata[2];
                            cfg_d.addr4     = cfg_wdata[1];
                        end
                        default:    cfg_d.ce_normal = cfg_wdata[0];
                    endcase
                end
                cfg_d.unlocked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.unlocked  <= 1'b0;
            cfg_q.timing    <= timing_t'(RESET_TIMING[TIM_W-1:0]);
            cfg_q.large_blk <= 1'b0;
            cfg_q.addr4     <= 1'b0;
            cfg_q.ce_normal <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign timing_o    = cfg_q.timing;
    assign large_blk_o = cfg_q.large_blk;
    assign addr4_o     = cfg_q.addr4;
    assign ce_normal_o = cfg_q.ce_normal;

    AST_LOCK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel != SEL_LOCK) |=> !cfg_q.unlocked);  // R7
    AST_LOCKED_TIMING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_TIMING && !cfg_q.unlocked) |=> $stable(cfg_q.timing));  // R7

endmodule

// File: rtl/nand_phase_cnt.sv
module nand_phase_cnt
    import nand_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/nand_cycle_fsm.sv
module nand_cycle_fsm
    import nand_strobe_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  timing_t           timing,
    input  logic              ce_normal,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_busy,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              stat_nand_rdy,
    output logic              stat_ctrl_rdy,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_i,
    input  logic              nand_rb_n
);

    typedef struct packed {
        phase_e            phase;
        xfer_kind_e        kind;
        logic              busy;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rb;
    } fsm_state_t;

    fsm_state_t       st_d, st_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             is_read;
    logic             bus_phase;

    nand_phase_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    assign is_read = (st_q.kind == KIND_READ);

    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        st_d.rb  = nand_rb_n;
        unique case (st_q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.phase = ST_SETUP;
                    st_d.kind  = xfer_kind_e'(req_kind);
                    st_d.busy  = req_busy;
                    st_d.wdata = req_wdata;
                    cnt_load   = 1'b1;
                    cnt_val    = CNT_W'(timing.ce_setup);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    st_d.phase = ST_LOW;
                    cnt_load   = 1'b1;
                    cnt_val    = is_read ? CNT_W'(timing.rd_low) : CNT_W'(timing.wr_low);
                end
            end
            ST_LOW: begin
                if (cnt_zero) begin
                    if (is_read) st_d.rdata = nand_dq_i;
                    st_d.phase = ST_HIGH;
                    cnt_load   = 1'b1;
                    cnt_val    = is_read ? CNT_W'(timing.rd_high) : CNT_W'(timing.wr_high);
                end
            end
            ST_HIGH: begin
                if (cnt_zero) begin
                    cnt_load = 1'b1;
                    if (is_read) begin
                        st_d.phase = ST_TURN;
                        cnt_val    = CNT_W'(timing.turn);
                    end else if (st_q.busy) begin
                        st_d.phase = ST_BUSY_DLY;
                        cnt_val    = CNT_W'(timing.busy_dly);
                    end else begin
                        st_d.phase = ST_DONE;
                    end
                end
            end
            ST_TURN: begin
                if (cnt_zero) st_d.phase = ST_DONE;
            end
            ST_BUSY_DLY: begin
                if (cnt_zero) st_d.phase = ST_BUSY_WAIT;
            end
            ST_BUSY_WAIT: begin
                if (st_q.rb) st_d.phase = ST_DONE;
            end
            default: begin  // ST_DONE
                st_d.phase = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= ST_IDLE;
            st_q.kind  <= KIND_CMD;
            st_q.busy  <= 1'b0;
            st_q.wdata <= '0;
            st_q.rdata <= '0;
            st_q.rb    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Pin decode from registered phase
    assign bus_phase     = (st_q.phase == ST_SETUP) || (st_q.phase == ST_LOW) ||
                           (st_q.phase == ST_HIGH);
    assign nand_ce_n     = ce_normal ? ((st_q.phase == ST_IDLE) || (st_q.phase == ST_DONE)) : 1'b0;
    assign nand_cle      = bus_phase && (st_q.kind == KIND_CMD);
    assign nand_ale      = bus_phase && (st_q.kind == KIND_ADDR);
    assign nand_we_n     = !((st_q.phase == ST_LOW) && !is_read);
    assign nand_re_n     = !((st_q.phase == ST_LOW) && is_read);
    assign nand_dq_oe    = bus_phase && !is_read;
    assign nand_dq_o     = st_q.wdata;
    assign rsp_rdata     = st_q.rdata;
    assign req_ack       = (st_q.phase == ST_DONE);
    assign stat_ctrl_rdy = (st_q.phase == ST_IDLE);
    assign stat_nand_rdy = st_q.rb;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);  // R5
    AST_IDLE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> stat_ctrl_rdy);  // R10
    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == ST_BUSY_WAIT && !stat_nand_rdy) |=> !req_ack);  // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));  // R11
    AST_CE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);  // R11
    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);  // R2
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);  // R3

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nand_strobe_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned CFG_W        = 32,
    parameter logic [31:0] UNLOCK_KEY   = 32'h0000_A25E,
    parameter logic [31:0] RESET_TIMING = 32'h03FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_busy,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              stat_nand_rdy,
    output logic              stat_ctrl_rdy,
    output logic              iface_large_blk,
    output logic              iface_addr4,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_i,
    input  logic              nand_rb_n
);

    timing_t timing;
    logic    ce_normal;

    nand_cfg_regs #(
        .CFG_W        (CFG_W),
        .UNLOCK_KEY   (UNLOCK_KEY),
        .RESET_TIMING (RESET_TIMING)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .timing_o    (timing),
        .large_blk_o (iface_large_blk),
        .addr4_o     (iface_addr4),
        .ce_normal_o (ce_normal)
    );

    nand_cycle_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .timing        (timing),
        .ce_normal     (ce_normal),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_busy      (req_busy),
        .req_wdata     (req_wdata),
        .req_ack       (req_ack),
        .rsp_rdata     (rsp_rdata),
        .stat_nand_rdy (stat_nand_rdy),
        .stat_ctrl_rdy (stat_ctrl_rdy),
        .nand_ce_n     (nand_ce_n),
        .nand_cle      (nand_cle),
        .nand_ale      (nand_ale),
        .nand_we_n     (nand_we_n),
        .nand_re_n     (nand_re_n),
        .nand_dq_o     (nand_dq_o),
        .nand_dq_oe    (nand_dq_oe),
        .nand_dq_i     (nand_dq_i),
        .nand_rb_n     (nand_rb_n)
    );

endmodule

// File: tb/test_nand_strobe_gen.sv
`timescale 1ns/1ps
module test_nand_strobe_gen;

    localparam logic [31:0] KEY = 32'h0000_A25E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_busy = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  rsp_rdata;
    logic        stat_nand_rdy, stat_ctrl_rdy, iface_large_blk, iface_addr4;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb_n = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    // per-request measurements
    int         m_cyc, m_we, m_re, m_pre, m_cle, m_ale, m_oe, m_rdy;
    logic [7:0] m_dq;
    logic [7:0] m_rdata;

    always #2.5 clk = ~clk;

    nand_strobe_gen i_nand_strobe_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_busy(req_busy), .req_wdata(req_wdata),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .stat_nand_rdy(stat_nand_rdy),
        .stat_ctrl_rdy(stat_ctrl_rdy), .iface_large_blk(iface_large_blk), .iface_addr4(iface_addr4),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int f_setup(input logic [31:0] t); return int'(t[25:24]) + 1; endfunction
    function automatic int f_low(input logic [31:0] t, input int kind);
        return (kind == 3) ? int'(t[11:8]) + 1 : int'(t[3:0]) + 1;
    endfunction
    function automatic int f_high(input logic [31:0] t, input int kind);
        return (kind == 3) ? int'(t[15:12]) + 1 : int'(t[7:4]) + 1;
    endfunction
    function automatic int exp_cycles(input logic [31:0] t, input int kind, input bit busy);
        int c;
        c = f_setup(t) + f_low(t, kind) + f_high(t, kind);
        if (kind == 3)  c += int'(t[18:16]) + 1;
        else if (busy)  c += int'(t[23:19]) + 2;  // delay plus one ready sample
        return c;
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_timing(input logic [31:0] t);
        cfg_write(2'd0, KEY);
        cfg_write(2'd1, t);
    endtask

    task automatic run_req(input int kind, input bit busy, input logic [7:0] wd, input logic [7:0] di);
        bit strobe_seen;
        m_cyc = 0; m_we = 0; m_re = 0; m_pre = 0; m_cle = 0; m_ale = 0; m_oe = 0; m_rdy = 0; m_dq = '0;
        strobe_seen = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind[1:0]; req_busy = busy; req_wdata = wd; nand_dq_i = di;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (req_ack) break;
            m_cyc++;
            if (!nand_we_n) m_we++;
            if (!nand_re_n) m_re++;
            if (!nand_we_n && !strobe_seen) m_dq = nand_dq_o;
            if (!nand_we_n || !nand_re_n) strobe_seen = 1'b1;
            if (!nand_ce_n && !strobe_seen) m_pre++;
            if (nand_cle) m_cle++;
            if (nand_ale) m_ale++;
            if (nand_dq_oe) m_oe++;
            if (stat_ctrl_rdy) m_rdy++;
        end
        m_rdata = rsp_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        check("R5", "ack width", int'(req_ack), 0);
    endtask

    task automatic check_req(input logic [31:0] t, input int kind, input bit busy,
                             input logic [7:0] wd, input logic [7:0] di);
        int span;
        run_req(kind, busy, wd, di);
        span = f_setup(t) + f_low(t, kind) + f_high(t, kind);
        check("R5", "cycles to ack", m_cyc, exp_cycles(t, kind, busy && kind != 3));
        check("R4", "ce setup", m_pre, f_setup(t));
        check("R10", "ctrl rdy while busy", m_rdy, 0);
        if (kind == 3) begin
            check("R3", "re low", m_re, f_low(t, kind));
            check("R3", "we low", m_we, 0);
            check("R3", "oe", m_oe, 0);
            check("R3", "rdata", int'(m_rdata), int'(di));
        end else begin
            check("R2", "we low", m_we, f_low(t, kind));
            check("R2", "re low", m_re, 0);
            check("R2", "oe span", m_oe, span);
            check("R2", "dq", int'(m_dq), int'(wd));
        end
        check("R2", "cle", m_cle, (kind == 0) ? span : 0);
        check("R2", "ale", m_ale, (kind == 1) ? span : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] t;
        void'($urandom(32'd4711));
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "ce_n in reset", int'(nand_ce_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "we_n", int'(nand_we_n), 1);
        check("R1", "re_n", int'(nand_re_n), 1);
        check("R1", "ce_n", int'(nand_ce_n), 1);
        check("R1", "oe", int'(nand_dq_oe), 0);
        check("R1", "ack", int'(req_ack), 0);
        check("R1", "ctrl rdy", int'(stat_ctrl_rdy), 1);
        check("R1", "iface", int'({iface_large_blk, iface_addr4}), 0);

        // R1 reset timing is all ones
        check_req(32'h03FF_FFFF, 2, 1'b0, 8'hA5, 8'h00);

        // All-zero timing, each kind
        set_timing(32'h0);
        for (int k = 0; k < 4; k++) check_req(32'h0, k, 1'b0, 8'h3C + 8'(k), 8'hC3);
        // All-ones timing, read and busy command
        set_timing(32'h03FF_FFFF);
        check_req(32'h03FF_FFFF, 3, 1'b0, 8'h00, 8'h5A);
        check_req(32'h03FF_FFFF, 0, 1'b1, 8'h10, 8'h00);   // R6 delay with ready pin high

        // Random timing words and kinds
        for (int n = 0; n < 12; n++) begin
            t = $urandom() & 32'h03FF_FFFF;
            set_timing(t);
            for (int r = 0; r < 4; r++) begin
                int  k  = int'($urandom_range(3, 0));
                bit  b  = 1'($urandom_range(1, 0));
                check_req(t, k, b, 8'($urandom()), 8'($urandom()));
            end
        end

        // R7 lock: no key, then one write per unlock, then a wrong key
        set_timing(32'h0000_0002);
        cfg_write(2'd1, 32'h0000_0009);
        check_req(32'h0000_0002, 2, 1'b0, 8'h11, 8'h00);   // R7 write ignored without key
        cfg_write(2'd0, KEY);
        cfg_write(2'd1, 32'h0000_0004);
        cfg_write(2'd1, 32'h0000_000B);
        check_req(32'h0000_0004, 2, 1'b0, 8'h22, 8'h00);   // R7 second write ignored
        cfg_write(2'd0, KEY + 32'd1);
        cfg_write(2'd1, 32'h0000_0007);
        check_req(32'h0000_0004, 2, 1'b0, 8'h33, 8'h00);   // R7 wrong key ignored

        // R8 interface bits
        cfg_write(2'd0, KEY);
        cfg_write(2'd2, 32'h0000_0006);
        @(negedge clk);
        check("R8", "large/addr4", int'({iface_large_blk, iface_addr4}), 3);
        cfg_write(2'd2, 32'h0000_0000);
        @(negedge clk);
        check("R7", "iface kept when locked", int'({iface_large_blk, iface_addr4}), 3);
        cfg_write(2'd0, KEY);
        cfg_write(2'd2, 32'h0000_0002);
        @(negedge clk);
        check("R8", "addr4 only", int'({iface_large_blk, iface_addr4}), 1);

        // R9 forced CE
        cfg_write(2'd0, KEY);
        cfg_write(2'd3, 32'h0000_0000);
        repeat (2) @(negedge clk);
        check("R9", "ce forced in idle", int'(nand_ce_n), 0);
        cfg_write(2'd0, KEY);
        cfg_write(2'd3, 32'h0000_0001);
        @(negedge clk);
        check("R9", "ce normal in idle", int'(nand_ce_n), 1);

        // R6/R10 busy hold with all-zero timing
        set_timing(32'h0);
        @(negedge clk);
        nand_rb_n = 1'b0;
        @(negedge clk);
        check("R10", "nand rdy low", int'(stat_nand_rdy), 0);
        req_valid = 1'b1; req_kind = 2'd0; req_busy = 1'b1; req_wdata = 8'h30;
        begin
            int acks = 0;
            int wait_c = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (req_ack) acks++;
            end
            check("R6", "ack while busy", acks, 0);
            nand_rb_n = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                wait_c++;
                if (req_ack) break;
            end
            check("R6", "clocks to ack after ready", wait_c, 2);
            check("R10", "nand rdy high", int'(stat_nand_rdy), 1);
            req_valid = 1'b0;
            @(negedge clk);
            check("R10", "ctrl rdy after ack", int'(stat_ctrl_rdy), 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule